// File: doc/BRIEF.md
# Configuration Header Clock-Ratio Detector

This block sits beside a passive-parallel configuration port and watches the 32-bit image words on their way to it. It counts the words that are actually accepted. From one header word it takes the encryption status, and from a later header word it takes the compression status. From these two flags and the selected port width (16 or 32 bits) it forms the clock-to-data ratio code for the configuration clock generator. The word stream passes to the port unchanged. The detector only observes it, and the downstream ready is routed straight back upstream.

A start pulse opens a new image. The ratio code and its valid flag appear once the compression word has been accepted, and they hold until the next start pulse or reset. An image that ends before the compression word arrives raises an error flag instead, and no ratio is produced for it.

Top module: `hdr_ratio_detect`

## Requirements
- R1: `up_ready_o` equals `dn_ready_i` in every cycle, combinationally, so the detector adds no backpressure.
- R2: A word is accepted only in a cycle where `word_valid_i` and `dn_ready_i` are both 1. Cycles without acceptance do not advance the word index.
- R3: The image is taken as encrypted when bits [3:2] of accepted word index 69 (zero-based) are not both zero.
- R4: The image is taken as compressed when bit 1 of accepted word index 229 is 0.
- R5: An image that is neither encrypted nor compressed yields code 0 (x1) at either width.
- R6: With `wide_i` = 0 (16-bit), a compressed image yields code 2 (x4) whether or not it is encrypted, and an encrypted-only image yields code 1 (x2).
- R7: With `wide_i` = 1 (32-bit), the non-x1 codes are one higher: compressed yields 3 (x8) and encrypted-only yields 2 (x4). `wide_i` is sampled in the cycle that word 229 is accepted.
- R8: `ratio_valid_o` is 0 after the edge that accepts word 228. It is 1 after the edge that accepts word 229, and it holds until a start pulse or reset. Later words leave `ratio_o` unchanged.
- R9: If a word with `last_i` = 1 is accepted at an index below 229, `short_err_o` rises after that edge. `ratio_valid_o` then stays 0 for that image.
- R10: A `start_i` pulse clears the index, `ratio_valid_o` and `short_err_o`. A word accepted in the same cycle as `start_i` counts as word 0 of the new image.
- R11: After reset, `ratio_o` = 0, `ratio_valid_o` = 0 and `short_err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | New-image start pulse |
| word_valid_i | input | 1 | Upstream word valid |
| word_i | input | 32 | Configuration word |
| last_i | input | 1 | Marks the final word of the image |
| dn_ready_i | input | 1 | Ready from the configuration port |
| up_ready_o | output | 1 | Ready returned upstream |
| wide_i | input | 1 | 1 = 32-bit port, 0 = 16-bit port |
| ratio_o | output | 2 | Ratio code: 0=x1, 1=x2, 2=x4, 3=x8 |
| ratio_valid_o | output | 1 | Ratio code is valid for this image |
| short_err_o | output | 1 | Image ended before word 229 |

## Verification
`up_ready_o` is combinational, so the bench checks it in the same cycle it drives `dn_ready_i`. The ratio code, the valid flag and the error flag each sit behind one register and are due right after the clock edge that accepts the deciding word. The bench therefore samples one time unit after that edge: after word 228 it expects the valid flag still low, and after word 229 it expects the valid flag and the code. After an image ends and after a start pulse, the bench samples again following the next edge. Because stalls are inserted at random, the deciding edge is found from the bench's own count of accepted words, never from a fixed cycle number.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;
  typedef enum logic [1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;

  localparam int unsigned ENC_WORD_IDX = 69;
  localparam int unsigned CMP_WORD_IDX = 229;
  localparam int unsigned ENC_FLD_LSB  = 2;
  localparam int unsigned ENC_FLD_MSB  = 3;
  localparam int unsigned CMP_FLD_BIT  = 1;
endpackage

// File: rtl/hdr_beat_ctr.sv
module hdr_beat_ctr #(
  parameter int unsigned LIMIT = 230,
  parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             beat_i,
  output logic [CNT_W-1:0] idx_o
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // index of the word in this cycle; a start makes it word 0
  assign idx_o = clr_i ? '0 : cnt_q;

  always_comb begin
    cnt_d = idx_o;
    if (beat_i && (idx_o != SAT)) cnt_d = idx_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr_i || beat_i)   cnt_q <= cnt_d;
  end

  assert_idx_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SAT);

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/hdr_ratio_enc.sv
module hdr_ratio_enc
  import hdr_ratio_pkg::*;
(
  input  logic   enc_i,
  input  logic   cmp_i,
  input  logic   wide_i,
  output ratio_e code_o
);
  logic [1:0] base;

  always_comb begin
    base = cmp_i ? 2'(RATIO_X4) : 2'(RATIO_X2);
    if (!enc_i && !cmp_i) code_o = RATIO_X1;
    else                  code_o = ratio_e'(base + {1'b0, wide_i});
  end
endmodule

// File: rtl/hdr_result_reg.sv
module hdr_result_reg
  import hdr_ratio_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned ENC_IDX = ENC_WORD_IDX,
  parameter int unsigned CMP_IDX = CMP_WORD_IDX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              beat_i,
  input  logic              last_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] word_i,
  input  ratio_e            code_i,
  output logic              enc_o,
  output ratio_e            code_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam logic [CNT_W-1:0] ENC_AT = CNT_W'(ENC_IDX);
  localparam logic [CNT_W-1:0] CMP_AT = CNT_W'(CMP_IDX);

  logic   enc_q, enc_d;
  logic   valid_q, valid_d;
  logic   err_q, err_d;
  ratio_e code_q, code_d;
  logic   err_base, valid_base;
  logic   hit_enc, hit_cmp, short_end;

  assign hit_enc   = beat_i && (idx_i == ENC_AT);
  assign hit_cmp   = beat_i && (idx_i == CMP_AT);
  assign short_end = beat_i && last_i && (idx_i < CMP_AT);

  always_comb begin
    err_base   = clr_i ? 1'b0 : err_q;
    valid_base = clr_i ? 1'b0 : valid_q;
    enc_d      = clr_i ? 1'b0 : enc_q;
    code_d     = clr_i ? RATIO_X1 : code_q;
    valid_d    = valid_base;
    err_d      = err_base;
    if (hit_enc) enc_d = |word_i[ENC_FLD_MSB:ENC_FLD_LSB];
    if (hit_cmp && !err_base) begin
      code_d  = code_i;
      valid_d = 1'b1;
    end
    if (short_end) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_q   <= 1'b0;
      code_q  <= RATIO_X1;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (clr_i || beat_i) begin
      enc_q   <= enc_d;
      code_q  <= code_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign enc_o   = enc_q;
  assign code_o  = code_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  assert_valid_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && err_q));

  assert_valid_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !clr_i) |=> valid_q);

  assert_code_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !clr_i) |=> $stable(code_q));

  assert_valid_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(beat_i && (idx_i == CMP_AT)));

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(beat_i && last_i));

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(beat_i && last_i)) |=> (!valid_q && !err_q));
endmodule

// File: rtl/hdr_ratio_detect.sv
module hdr_ratio_detect
  import hdr_ratio_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ENC_IDX = ENC_WORD_IDX,
  parameter int unsigned CMP_IDX = CMP_WORD_IDX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              word_valid_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              last_i,
  input  logic              dn_ready_i,
  output logic              up_ready_o,
  input  logic              wide_i,
  output logic [1:0]        ratio_o,
  output logic              ratio_valid_o,
  output logic              short_err_o
);
  localparam int unsigned LIMIT = CMP_IDX + 1;
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);

  logic             beat;
  logic [CNT_W-1:0] idx;
  logic             enc_flag;
  ratio_e           code_now, code_held;

  assign up_ready_o = dn_ready_i;
  assign beat       = word_valid_i && dn_ready_i;

  hdr_beat_ctr #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_i),
    .beat_i (beat),
    .idx_o  (idx)
  );

  hdr_ratio_enc u_enc (
    .enc_i  (enc_flag),
    .cmp_i  (~word_i[CMP_FLD_BIT]),
    .wide_i (wide_i),
    .code_o (code_now)
  );

  hdr_result_reg #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .ENC_IDX(ENC_IDX),
    .CMP_IDX(CMP_IDX)
  ) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start_i),
    .beat_i  (beat),
    .last_i  (last_i),
    .idx_i   (idx),
    .word_i  (word_i),
    .code_i  (code_now),
    .enc_o   (enc_flag),
    .code_o  (code_held),
    .valid_o (ratio_valid_o),
    .err_o   (short_err_o)
  );

  assign ratio_o = 2'(code_held);
endmodule

// File: tb/hdr_ratio_detect_test.sv
module hdr_ratio_detect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, word_valid_i = 1'b0, last_i = 1'b0;
  logic        dn_ready_i = 1'b0, wide_i = 1'b0;
  logic [31:0] word_i = '0;
  logic        up_ready_o, ratio_valid_o, short_err_o;
  logic [1:0]  ratio_o;
  int          n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  hdr_ratio_detect uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_valid_i(word_valid_i),
    .word_i(word_i), .last_i(last_i), .dn_ready_i(dn_ready_i),
    .up_ready_o(up_ready_o), .wide_i(wide_i), .ratio_o(ratio_o),
    .ratio_valid_o(ratio_valid_o), .short_err_o(short_err_o)
  );

  function automatic logic [1:0] exp_code(logic e, logic c, logic w);
    if (!e && !c) return 2'd0;
    return 2'((c ? 2 : 1) + int'(w));
  endfunction

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one image of n words; encb goes to word 69 bits[3:2], c1 to word 229 bit 1
  task automatic run_image(int n, logic [1:0] encb, logic c1, logic wide,
                           int stall_pct, bit start_with_beat);
    logic e, c;
    logic [1:0] ec;
    e  = (encb != 2'b00);
    c  = !c1;
    ec = exp_code(e, c, wide);
    if (!start_with_beat) begin
      @(negedge clk);
      start_i = 1'b1; word_valid_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      chk("R10 start clears valid", int'(ratio_valid_o), 0);
      chk("R10 start clears err", int'(short_err_o), 0);
    end
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      bit acc, first;
      w = $urandom;
      if (i == 69) w[3:2] = encb;
      if (i == 229) w[1] = c1;
      acc = 0; first = 1;
      while (!acc) begin
        @(negedge clk);
        start_i      = start_with_beat && (i == 0) && first;
        word_valid_i = (($urandom % 100) >= stall_pct);
        dn_ready_i   = (($urandom % 100) >= stall_pct);
        word_i       = w;
        last_i       = (i == n - 1);
        wide_i       = (i == 229) ? wide : 1'($urandom);
        first        = 0;
        #1;
        chk("R1 ready passthrough", int'(up_ready_o), int'(dn_ready_i));
        @(posedge clk);
        acc = word_valid_i && dn_ready_i;
        #1;
        if (acc && i == 228) chk("R8 valid not before word 229", int'(ratio_valid_o), 0);
        if (acc && i == 229) begin
          chk("R8 valid after word 229 (R2 counting)", int'(ratio_valid_o), 1);
          chk("R3/R4/R5/R6/R7 ratio code", int'(ratio_o), int'(ec));
        end
      end
    end
    @(negedge clk);
    word_valid_i = 1'b0; last_i = 1'b0; start_i = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    if (n >= 230) begin
      chk("R8 valid held", int'(ratio_valid_o), 1);
      chk("R8 code unchanged by later words", int'(ratio_o), int'(ec));
      chk("R9 no error on full image", int'(short_err_o), 0);
    end else begin
      chk("R9 short image error", int'(short_err_o), 1);
      chk("R9 no valid on short image", int'(ratio_valid_o), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset code", int'(ratio_o), 0);
    chk("R11 reset valid", int'(ratio_valid_o), 0);
    chk("R11 reset err", int'(short_err_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed: every enc/cmp/width combination on a full image
    for (int k = 0; k < 8; k++) begin
      run_image(232, (k[0] ? 2'b01 : 2'b00), ~k[1], k[2], 0, 0);
    end
    run_image(230, 2'b10, 1'b1, 1'b1, 20, 0);  // R3 upper bit, exact length
    run_image(230, 2'b11, 1'b0, 1'b0, 20, 0);
    run_image(229, 2'b01, 1'b0, 1'b1, 10, 0);  // R9 one word short
    run_image(1,   2'b00, 1'b1, 1'b0, 0,  1);  // R9/R10 start with single last word
    run_image(240, 2'b01, 1'b0, 1'b1, 30, 1);  // R10 start in same cycle as word 0

    // random images
    for (int k = 0; k < 12; k++) begin
      int len;
      len = (($urandom % 10) < 7) ? 230 + int'($urandom % 20) : 1 + int'($urandom % 229);
      run_image(len, 2'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom % 40), bit'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule